// File: doc/BRIEF.md
# Network Controller Port Register File

This block is the set of four 16-bit port registers that a processor sees for an emulated Ethernet controller. It sits between two parties: the local processor bus, which does word writes and high-byte-only writes, and a remote service channel, which carries out the commands the processor posts. The block does not carry out any command itself. It captures port commands, keeps track of a busy condition and of resets that are waiting, and pulses an attention line so the remote side knows there is work. It also holds the interrupt flags and turns them into an interrupt request with a fixed vector.

The two sides follow different access rules. The remote side raises interrupt flags and the local side clears them by writing ones. The status register is written only from the remote side. The port control block base is written only from the local side. While a command is still in service, the first command stays latched for the remote side. A later command replaces only the visible command field and sets a flag that records the overwrite.

Top module: `netctl_port_regs`

## Requirements
- R1: After reset every register reads 0 on both sides, and `attn_o` and `irq_o` are low.
- R2: Word offset 2 holds base bits 15:1 and its bit 0 always reads 0. Word offset 3 keeps only bits 1:0. A word write of 0xFFFF therefore reads back as 0xFFFE at offset 2 and 0x0003 at offset 3. A high-byte write to offset 2 changes only bits 15:8. Both registers read the same from the remote side.
- R3: The status register at offset 1 is written only by the remote side and keeps bits 15, 14, 7, 4 and 3:0, with all other bits reading 0. A local write to it has no effect.
- R4: At offset 0 the flags sit in bits 15:10 and bit 8, and bit 9 always reads 0. A remote write to offset 0 sets every flag whose bit is 1 in data bits 15:8. A local write (word or high byte) clears every flag whose bit is 1. Bit 7 reads as the OR of all flags.
- R5: Bit 6 is the interrupt enable and is written by local word writes only. Any change of its value sets the flag in bit 11. A local high-byte write leaves bit 6 and the command field unchanged.
- R6: A local word write with bit 5 clear loads data bits 3:0 into the command field. If the value is nonzero and the block is idle, the block latches it for the remote side, becomes busy, and pulses `attn_o` high for one cycle after the write edge. Command 0 gives no pulse.
- R7: A nonzero command written while busy updates the visible command field, keeps the latched copy, sets the overwrite flag and gives no pulse. A remote read of offset 0 (`rem_rd_i`) clears the overwrite flag and has no other side effect.
- R8: A local word write with bit 5 set leaves the command field at 0 and bit 5 reading 0. It forces status bits 3:0 to 0, sets busy and the reset request, and pulses `attn_o`. A remote write with bit 5 set clears the reset request and busy.
- R9: `bus_reset_i` clears the local view of offset 0 to 0, forces status bits 3:0 to 0, sets busy and the bus-reset request, and pulses `attn_o`. A remote write with bit 4 set clears that request and busy. A remote write with bit 7 set clears busy alone.
- R10: The remote view of offset 0 is {latched command[15:12], busy[11], overwrite flag[10], reset request[9], bus-reset request[8], 0[7:4], command[3:0]}.
- R11: `irq_o` is high only while bit 7 and bit 6 are both 1. It rises when that condition becomes true, falls on `irq_ack_i`, and rises again after a local write to offset 0 that leaves flags pending. `irq_vec_o` carries `VECTOR` while `irq_o` is high and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lcl_wr_i | input | 1 | Local write strobe |
| lcl_hi_only_i | input | 1 | Local write affects only the high byte |
| lcl_addr_i | input | 2 | Local word offset |
| lcl_wdata_i | input | 16 | Local write data |
| lcl_rdata_o | output | 16 | Local read data for `lcl_addr_i` |
| rem_wr_i | input | 1 | Remote write strobe |
| rem_rd_i | input | 1 | Remote read strobe (side effect at offset 0) |
| rem_addr_i | input | 2 | Remote word offset |
| rem_wdata_i | input | 16 | Remote write data |
| rem_rdata_o | output | 16 | Remote read data for `rem_addr_i` |
| bus_reset_i | input | 1 | Processor bus reset |
| attn_o | output | 1 | One-cycle attention pulse to the remote side |
| irq_o | output | 1 | Interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_vec_o | output | 9 | Interrupt vector |

## Verification
The hardest state to reach is an overwrite while busy that is followed by a remote read. Reaching it takes two local command writes with no remote clear between them. After that, the remote view must be observed once passively and once with the read strobe, to tell the side effect apart from plain reading. The stimulus also brings up a second interrupt by acknowledging with two flags pending and then clearing only one of them from the local side. The register masks and flag behaviour run from a vector table.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
  localparam int DATA_W = 16;
  localparam int CMD_W  = 4;
  localparam int FLAG_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CSR  = 2'd0,
    REG_STAT = 2'd1,
    REG_BLO  = 2'd2,
    REG_BHI  = 2'd3
  } reg_sel_e;

  // flag byte: bit1 (word bit 9) unimplemented
  localparam logic [FLAG_W-1:0] FLAG_MASK = 8'hFD;
  localparam int                FLAG_DONE = 3; // word bit 11
  localparam logic [DATA_W-1:0] STAT_MASK = 16'hC09F;
  localparam logic [CMD_W-1:0]  ST_RESET  = '0;
endpackage

// File: rtl/ncr_cmd.sv
module ncr_cmd
  import netctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lcl_wr_i,
  input  logic             lcl_rset_i,
  input  logic [CMD_W-1:0] lcl_cmd_i,
  input  logic             rem_wr_i,
  input  logic             rem_clr_busy_i,
  input  logic             rem_clr_rset_i,
  input  logic             rem_clr_brst_i,
  input  logic             rem_rd_i,
  input  logic             bus_reset_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic [CMD_W-1:0] cmd_bp_o,
  output logic             busy_o,
  output logic             ovr_o,
  output logic             rset_req_o,
  output logic             brst_req_o,
  output logic             attn_o,
  output logic             state_rst_o
);
  assign state_rst_o = bus_reset_i | (lcl_wr_i & lcl_rset_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o      <= '0;
      cmd_bp_o   <= '0;
      busy_o     <= 1'b0;
      ovr_o      <= 1'b0;
      rset_req_o <= 1'b0;
      brst_req_o <= 1'b0;
      attn_o     <= 1'b0;
    end else begin
      attn_o <= 1'b0;
      if (rem_rd_i) ovr_o <= 1'b0;
      if (rem_wr_i) begin
        if (rem_clr_busy_i | rem_clr_rset_i | rem_clr_brst_i) busy_o <= 1'b0;
        if (rem_clr_rset_i) rset_req_o <= 1'b0;
        if (rem_clr_brst_i) brst_req_o <= 1'b0;
      end
      // local events win over a same-cycle remote clear
      if (bus_reset_i) begin
        cmd_o      <= '0;
        busy_o     <= 1'b1;
        brst_req_o <= 1'b1;
        ovr_o      <= 1'b0;
        attn_o     <= 1'b1;
      end else if (lcl_wr_i) begin
        if (lcl_rset_i) begin
          cmd_o      <= '0;
          busy_o     <= 1'b1;
          rset_req_o <= 1'b1;
          attn_o     <= 1'b1;
        end else begin
          cmd_o <= lcl_cmd_i;
          if (lcl_cmd_i != '0) begin
            if (busy_o) begin
              ovr_o <= 1'b1;
            end else begin
              cmd_bp_o <= lcl_cmd_i;
              busy_o   <= 1'b1;
              attn_o   <= 1'b1;
            end
          end
        end
      end
    end
  end

  a_r6_attn_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attn_o |-> busy_o);
  a_r7_keep_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcl_wr_i && !lcl_rset_i && !bus_reset_i && busy_o && lcl_cmd_i != '0)
    |=> ($stable(cmd_bp_o) && ovr_o && !attn_o));
  a_r8_rset_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcl_wr_i && lcl_rset_i && !bus_reset_i) |=> (rset_req_o && busy_o && cmd_o == '0));
  a_r9_brst_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (brst_req_o && busy_o && attn_o));
endmodule

// File: rtl/ncr_irq.sv
module ncr_irq
  import netctl_pkg::*;
#(
  parameter int              VEC_W  = 9,
  parameter logic [VEC_W-1:0] VECTOR = 9'o120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lcl_wr_i,
  input  logic              lcl_word_i,
  input  logic [FLAG_W-1:0] lcl_hi_i,
  input  logic              lcl_inte_i,
  input  logic              rem_set_i,
  input  logic [FLAG_W-1:0] rem_hi_i,
  input  logic              bus_reset_i,
  input  logic              irq_ack_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              inte_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  logic [FLAG_W-1:0] flags_n;
  logic              inte_n, cond_q, cond_n;

  always_comb begin
    flags_n = flags_o;
    inte_n  = inte_o;
    if (lcl_wr_i) flags_n = flags_n & ~lcl_hi_i;
    if (lcl_wr_i && lcl_word_i) begin
      inte_n = lcl_inte_i;
      if (lcl_inte_i != inte_o) flags_n[FLAG_DONE] = 1'b1;
    end
    if (rem_set_i) flags_n = flags_n | rem_hi_i;
    flags_n = flags_n & FLAG_MASK;
    if (bus_reset_i) begin
      flags_n = '0;
      inte_n  = 1'b0;
    end
  end

  assign cond_q = (|flags_o) & inte_o;
  assign cond_n = (|flags_n) & inte_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      inte_o  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      flags_o <= flags_n;
      inte_o  <= inte_n;
      if (!cond_n)                    irq_o <= 1'b0;
      else if (lcl_wr_i || !cond_q)   irq_o <= 1'b1; // new condition or handler left flags
      else if (irq_ack_i)             irq_o <= 1'b0;
    end
  end

  assign irq_vec_o = irq_o ? VECTOR : '0;

  a_r11_irq_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((|flags_o) && inte_o));
  a_r11_ack_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_ack_i && !lcl_wr_i && !rem_set_i) |=> !irq_o);
  a_r4_remote_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_set_i && !bus_reset_i) |=>
      ((flags_o & $past(rem_hi_i) & FLAG_MASK) == ($past(rem_hi_i) & FLAG_MASK)));
endmodule

// File: rtl/ncr_store.sv
module ncr_store
  import netctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lcl_wr_i,
  input  logic              lcl_hi_only_i,
  input  logic [ADDR_W-1:0] lcl_addr_i,
  input  logic [DATA_W-1:0] lcl_wdata_i,
  input  logic              rem_wr_i,
  input  logic [ADDR_W-1:0] rem_addr_i,
  input  logic [DATA_W-1:0] rem_wdata_i,
  input  logic              state_rst_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] blo_o,
  output logic [DATA_W-1:0] bhi_o
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:1] blo_q;
  logic [1:0]        bhi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      blo_q  <= '0;
      bhi_q  <= '0;
    end else begin
      if (rem_wr_i && rem_addr_i == REG_STAT) stat_q <= rem_wdata_i & STAT_MASK;
      if (state_rst_i) stat_q[CMD_W-1:0] <= ST_RESET;
      if (lcl_wr_i && lcl_addr_i == REG_BLO) begin
        blo_q[DATA_W-1:HALF] <= lcl_wdata_i[DATA_W-1:HALF];
        if (!lcl_hi_only_i) blo_q[HALF-1:1] <= lcl_wdata_i[HALF-1:1];
      end
      if (lcl_wr_i && !lcl_hi_only_i && lcl_addr_i == REG_BHI) bhi_q <= lcl_wdata_i[1:0];
    end
  end

  assign stat_o = stat_q;
  assign blo_o  = {blo_q, 1'b0};
  assign bhi_o  = {{(DATA_W-2){1'b0}}, bhi_q};

  a_r3_local_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcl_wr_i && !state_rst_i && !(rem_wr_i && rem_addr_i == REG_STAT)) |=> $stable(stat_o));
  a_r2_bhi_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcl_wr_i && lcl_hi_only_i) |=> $stable(bhi_o));
endmodule

// File: rtl/netctl_port_regs.sv
module netctl_port_regs
  import netctl_pkg::*;
#(
  parameter int               VEC_W  = 9,
  parameter logic [VEC_W-1:0] VECTOR = 9'o120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lcl_wr_i,
  input  logic              lcl_hi_only_i,
  input  logic [ADDR_W-1:0] lcl_addr_i,
  input  logic [DATA_W-1:0] lcl_wdata_i,
  output logic [DATA_W-1:0] lcl_rdata_o,
  input  logic              rem_wr_i,
  input  logic              rem_rd_i,
  input  logic [ADDR_W-1:0] rem_addr_i,
  input  logic [DATA_W-1:0] rem_wdata_i,
  output logic [DATA_W-1:0] rem_rdata_o,
  input  logic              bus_reset_i,
  output logic              attn_o,
  output logic              irq_o,
  input  logic              irq_ack_i,
  output logic [VEC_W-1:0]  irq_vec_o
);
  localparam int HALF = DATA_W / 2;

  logic lcl_csr_wr, lcl_csr_word, rem_csr_wr, rem_csr_rd;
  logic [CMD_W-1:0]  cmd, cmd_bp;
  logic busy, ovr, rset_req, brst_req, state_rst, inte;
  logic [FLAG_W-1:0] flags;
  logic [DATA_W-1:0] stat, blo, bhi, csr_lcl, csr_rem;

  assign lcl_csr_wr   = lcl_wr_i && lcl_addr_i == REG_CSR;
  assign lcl_csr_word = lcl_csr_wr && !lcl_hi_only_i;
  assign rem_csr_wr   = rem_wr_i && rem_addr_i == REG_CSR;
  assign rem_csr_rd   = rem_rd_i && rem_addr_i == REG_CSR;

  ncr_cmd u_cmd (
    .clk_i, .rst_ni,
    .lcl_wr_i      (lcl_csr_word),
    .lcl_rset_i    (lcl_wdata_i[5]),
    .lcl_cmd_i     (lcl_wdata_i[CMD_W-1:0]),
    .rem_wr_i      (rem_csr_wr),
    .rem_clr_busy_i(rem_wdata_i[7]),
    .rem_clr_rset_i(rem_wdata_i[5]),
    .rem_clr_brst_i(rem_wdata_i[4]),
    .rem_rd_i      (rem_csr_rd),
    .bus_reset_i,
    .cmd_o(cmd), .cmd_bp_o(cmd_bp), .busy_o(busy), .ovr_o(ovr),
    .rset_req_o(rset_req), .brst_req_o(brst_req), .attn_o,
    .state_rst_o(state_rst)
  );

  ncr_irq #(.VEC_W(VEC_W), .VECTOR(VECTOR)) u_irq (
    .clk_i, .rst_ni,
    .lcl_wr_i   (lcl_csr_wr),
    .lcl_word_i (!lcl_hi_only_i),
    .lcl_hi_i   (lcl_wdata_i[DATA_W-1:HALF]),
    .lcl_inte_i (lcl_wdata_i[6]),
    .rem_set_i  (rem_csr_wr),
    .rem_hi_i   (rem_wdata_i[DATA_W-1:HALF]),
    .bus_reset_i, .irq_ack_i,
    .flags_o(flags), .inte_o(inte), .irq_o, .irq_vec_o
  );

  ncr_store u_store (
    .clk_i, .rst_ni, .lcl_wr_i, .lcl_hi_only_i, .lcl_addr_i, .lcl_wdata_i,
    .rem_wr_i, .rem_addr_i, .rem_wdata_i,
    .state_rst_i(state_rst),
    .stat_o(stat), .blo_o(blo), .bhi_o(bhi)
  );

  assign csr_lcl = {flags, |flags, inte, 2'b00, cmd};
  assign csr_rem = {cmd_bp, busy, ovr, rset_req, brst_req, 4'h0, cmd};

  always_comb begin
    unique case (lcl_addr_i)
      REG_CSR:  lcl_rdata_o = csr_lcl;
      REG_STAT: lcl_rdata_o = stat;
      REG_BLO:  lcl_rdata_o = blo;
      default:  lcl_rdata_o = bhi;
    endcase
    unique case (rem_addr_i)
      REG_CSR:  rem_rdata_o = csr_rem;
      REG_STAT: rem_rdata_o = stat;
      REG_BLO:  rem_rdata_o = blo;
      default:  rem_rdata_o = bhi;
    endcase
  end

  a_r9_state_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (stat[CMD_W-1:0] == ST_RESET && flags == '0 && !inte && cmd == '0));
  a_r7_ovr_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr) |-> $past(busy));
endmodule

// File: tb/netctl_port_regs_test.sv
module netctl_port_regs_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        lcl_wr_i = 0, lcl_hi_only_i = 0, rem_wr_i = 0, rem_rd_i = 0;
  logic [1:0]  lcl_addr_i = 0, rem_addr_i = 0;
  logic [15:0] lcl_wdata_i = 0, rem_wdata_i = 0, lcl_rdata_o, rem_rdata_o;
  logic        bus_reset_i = 0, attn_o, irq_o, irq_ack_i = 0;
  logic [8:0]  irq_vec_o;
  int errs = 0, checks = 0;

  netctl_port_regs uut (.*);

  always #10 clk_i = ~clk_i;

  // {op, waddr, wdata, remote_read, raddr, expected, req}; op 0 local word, 1 local high, 2 remote
  localparam int NV = 14;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 2'd2, 16'hFFFF, 1'b0, 2'd2, 16'hFFFE, 4'd2},  // R2
    {2'd0, 2'd3, 16'hFFFF, 1'b0, 2'd3, 16'h0003, 4'd2},  // R2
    {2'd1, 2'd2, 16'hAB00, 1'b0, 2'd2, 16'hABFE, 4'd2},  // R2 high byte only
    {2'd0, 2'd2, 16'h1234, 1'b1, 2'd2, 16'h1234, 4'd2},  // R2 remote view
    {2'd2, 2'd1, 16'hFFFF, 1'b0, 2'd1, 16'hC09F, 4'd3},  // R3
    {2'd0, 2'd1, 16'h0000, 1'b0, 2'd1, 16'hC09F, 4'd3},  // R3 local ignored
    {2'd2, 2'd1, 16'h0002, 1'b0, 2'd1, 16'h0002, 4'd3},  // R3
    {2'd2, 2'd0, 16'hFF00, 1'b0, 2'd0, 16'hFD80, 4'd4},  // R4
    {2'd0, 2'd0, 16'h8000, 1'b0, 2'd0, 16'h7D80, 4'd4},  // R4
    {2'd1, 2'd0, 16'h7D00, 1'b0, 2'd0, 16'h0000, 4'd4},  // R4
    {2'd0, 2'd0, 16'h0040, 1'b0, 2'd0, 16'h08C0, 4'd5},  // R5
    {2'd1, 2'd0, 16'h0800, 1'b0, 2'd0, 16'h0040, 4'd5},  // R5 high write keeps enable
    {2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0880, 4'd5},  // R5
    {2'd0, 2'd0, 16'h0800, 1'b0, 2'd0, 16'h0000, 4'd4}   // R4
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic lwr(input logic [1:0] a, input logic [15:0] d, input logic hi);
    @(negedge clk_i);
    lcl_wr_i = 1; lcl_addr_i = a; lcl_wdata_i = d; lcl_hi_only_i = hi;
    @(negedge clk_i);
    lcl_wr_i = 0; lcl_hi_only_i = 0;
  endtask

  task automatic rwr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    rem_wr_i = 1; rem_addr_i = a; rem_wdata_i = d;
    @(negedge clk_i);
    rem_wr_i = 0;
  endtask

  task automatic rrd_strobe(input logic [1:0] a);
    @(negedge clk_i);
    rem_rd_i = 1; rem_addr_i = a;
    @(negedge clk_i);
    rem_rd_i = 0;
  endtask

  task automatic lrd(input logic [1:0] a, output logic [15:0] d);
    lcl_addr_i = a; #1; d = lcl_rdata_o;
  endtask

  task automatic rrd(input logic [1:0] a, output logic [15:0] d);
    rem_addr_i = a; #1; d = rem_rdata_o;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      lrd(2'(a), v); chk("R1 local", v, 16'h0);
      rrd(2'(a), v); chk("R1 remote", v, 16'h0);
    end
    chk("R1 attn/irq", {14'h0, attn_o, irq_o}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] e;
      e = VEC[i];
      if (e[42:41] == 2'd2) rwr(e[40:39], e[38:23]);
      else lwr(e[40:39], e[38:23], e[41]);
      if (e[22]) rrd(e[21:20], v); else lrd(e[21:20], v);
      chk($sformatf("R%0d vector %0d", e[3:0], i), v, e[19:4]);
    end

    // R6 command capture and attention
    lwr(2'd0, 16'h0002, 0);
    chk("R6 attn pulse", {15'h0, attn_o}, 16'h1);
    rrd(2'd0, v); chk("R6/R10 remote csr", v, 16'h2802);
    @(negedge clk_i);
    chk("R6 attn one cycle", {15'h0, attn_o}, 16'h0);
    rwr(2'd0, 16'h0080);
    rrd(2'd0, v); chk("R9 busy clear", v, 16'h2002);
    lwr(2'd0, 16'h0000, 0);
    chk("R6 noop no attn", {15'h0, attn_o}, 16'h0);
    lrd(2'd0, v); chk("R6 noop csr", v, 16'h0);

    // R7 overwrite while busy
    lwr(2'd0, 16'h0002, 0);
    chk("R7 first attn", {15'h0, attn_o}, 16'h1);
    lwr(2'd0, 16'h0008, 0);
    chk("R7 no second attn", {15'h0, attn_o}, 16'h0);
    lrd(2'd0, v); chk("R7 visible cmd", v, 16'h0008);
    rrd(2'd0, v); chk("R7 passive view", v, 16'h2C08);
    rrd(2'd0, v); chk("R7 passive no effect", v, 16'h2C08);
    rrd_strobe(2'd0);
    rrd(2'd0, v); chk("R7 read clears", v, 16'h2808);
    rrd_strobe(2'd0);
    rrd(2'd0, v); chk("R7 second read", v, 16'h2808);
    rwr(2'd0, 16'h0080);
    lwr(2'd0, 16'h0000, 0);

    // R8 local reset command
    rwr(2'd1, 16'h0002);
    lwr(2'd0, 16'h0020, 0);
    chk("R8 attn", {15'h0, attn_o}, 16'h1);
    lrd(2'd0, v); chk("R8 csr reads 0", v, 16'h0);
    lrd(2'd1, v); chk("R8 state reset", v, 16'h0);
    rrd(2'd0, v); chk("R8 remote view", v, 16'h2A00);
    rwr(2'd0, 16'h0020);
    rrd(2'd0, v); chk("R8 remote clear", v, 16'h2000);

    // R9 bus reset
    rwr(2'd1, 16'h0002);
    rwr(2'd0, 16'h1000);
    lwr(2'd0, 16'h0041, 0);
    rwr(2'd0, 16'h0080);
    @(negedge clk_i); bus_reset_i = 1;
    @(negedge clk_i); bus_reset_i = 0;
    chk("R9 attn", {15'h0, attn_o}, 16'h1);
    lrd(2'd0, v); chk("R9 csr cleared", v, 16'h0);
    lrd(2'd1, v); chk("R9 state reset", v, 16'h0);
    rrd(2'd0, v); chk("R9 remote view", v, 16'h1900);
    chk("R9 irq low", {15'h0, irq_o}, 16'h0);
    rwr(2'd0, 16'h0010);
    rrd(2'd0, v); chk("R9 request cleared", v, 16'h1000);

    // R11 interrupt request
    lwr(2'd0, 16'h0040, 0);
    chk("R11 enable raises irq", {15'h0, irq_o}, 16'h1);
    lwr(2'd0, 16'h0800, 1);
    chk("R11 cleared drops irq", {15'h0, irq_o}, 16'h0);
    rwr(2'd0, 16'h3000);
    chk("R11 remote flags irq", {15'h0, irq_o}, 16'h1);
    chk("R11 vector", {7'h0, irq_vec_o}, 16'h0050);
    @(negedge clk_i); irq_ack_i = 1;
    @(negedge clk_i); irq_ack_i = 0;
    chk("R11 ack drops", {15'h0, irq_o}, 16'h0);
    chk("R11 vector idle", {7'h0, irq_vec_o}, 16'h0);
    repeat (3) @(negedge clk_i);
    chk("R11 no spontaneous", {15'h0, irq_o}, 16'h0);
    lwr(2'd0, 16'h2000, 1);
    chk("R11 second request", {15'h0, irq_o}, 16'h1);
    lrd(2'd0, v); chk("R11 pending flags", v, 16'h10C0);
    @(negedge clk_i); irq_ack_i = 1;
    @(negedge clk_i); irq_ack_i = 0;
    lwr(2'd0, 16'h1000, 1);
    chk("R11 all clear", {15'h0, irq_o}, 16'h0);

    finish_run();
  end
endmodule